// File: doc/BRIEF.md
# Serial Flash Transaction Sequencer

This block runs one transaction on a serial flash bus from a descriptor that is presented together with a start pulse. The descriptor holds an opcode byte, an address of up to three bytes, the number of address bytes (0 to 3), a count of turnaround (dummy) cycles, a data byte count of up to 4096, and two lane-width selectors, one for the address phase and one for the data phase. A direction bit chooses whether the data phase transmits or receives. The same descriptor shape serves array reads on one, two or four lanes, program loads, random-data loads, feature-register get and set, and die selection. Only the fields differ.

The block drives chip select, a mode-0 serial clock (idle low, input sampled on the rising edge, output changed on the falling edge) and four IO lanes. Each lane has an output value, an output enable and an input, so the lanes can feed a pad tristate. Outgoing data is pulled byte by byte from a byte input with a one-cycle take strobe. Incoming data leaves as bytes with a one-cycle valid strobe. A busy flag covers the whole transaction, including the deselect gap that follows it.

Top module: `sflash_seq`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, busy_o is 0, io_oe_o is 0, and rx_valid_o and tx_pop_o are 0.
- R2: A start_i pulse seen while busy_o is 0 latches the descriptor, and busy_o is 1 from the next cycle until the deselect gap ends. A start_i or descriptor change while busy_o is 1 has no effect on the running transaction and starts no further one.
- R3: Every transaction begins with the opcode on IO lane 0 alone (io_oe_o = 0001), most significant bit first, over 8 serial-clock cycles.
- R4: The address phase sends alen_i bytes, most significant byte first, taken from the low alen_i bytes of addr_i. Lane codes are 0 = x1 on lane 0, 1 = x2 on lanes 1:0, 2 = x4 on lanes 3:0. On wide lanes, the earlier (higher) bits go on the higher-numbered lane. With alen_i = 0 the phase is skipped.
- R5: The dummy phase lasts exactly dummy_i serial-clock cycles with io_oe_o = 0000, and it is skipped when dummy_i is 0.
- R6: In a write (write_i = 1), dlen_i bytes are sent with the data lane code, using the same bit-to-lane rule as R4. Each byte is taken from tx_data_i in the cycle where tx_pop_o is 1, with exactly one pulse per byte.
- R7: In a read (write_i = 0), all lanes are released during the data phase. Input is sampled at each rising serial-clock edge: x1 from lane 1, x2 from lanes 1:0, x4 from lanes 3:0, and the first sample holds the byte's top bits. Each complete byte appears on rx_data_o with a one-cycle rx_valid_o pulse, dlen_i pulses in total.
- R8: sclk_o has a period of CLK_DIV system clocks and stays low while cs_n_o is 1. A transaction gives exactly 8 + alen*(8/aw) + dummy + dlen*(8/dw) rising edges, where aw and dw are the lane counts.
- R9: Between two transactions cs_n_o stays high for at least 2*CLK_DIV system clocks, and busy_o stays 1 during that gap.
- R10: A zero data count ends the transaction after the last non-empty phase. An opcode-only descriptor produces exactly 8 serial-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cmd_i | input | 8 | Opcode byte |
| addr_i | input | 24 | Address value, right-aligned |
| alen_i | input | 2 | Number of address bytes, 0 to 3 |
| addr_lanes_i | input | 2 | Address lane code: 0 x1, 1 x2, 2 x4 |
| dummy_i | input | 5 | Number of dummy cycles |
| dlen_i | input | 13 | Number of data bytes, 0 to 4096 |
| data_lanes_i | input | 2 | Data lane code: 0 x1, 1 x2, 2 x4 |
| write_i | input | 1 | 1 transmits data, 0 receives |
| tx_data_i | input | 8 | Next byte to send |
| tx_pop_o | output | 1 | tx_data_i is taken at the end of this cycle |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | rx_data_o is valid this cycle |
| busy_o | output | 1 | Transaction or deselect gap in progress |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, mode 0 |
| io_out_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_in_i | input | 4 | Lane input values |

## Verification
The bench builds the block with CLK_DIV = 6 and keeps the default limits of 4096 data bytes and 31 dummy cycles. A divider that is not a power of two, with three-clock half periods, exposes off-by-one errors in the edge counter and the tail and gap waits. The 4096 limit lets the bench run a full-length x4 read, which loads the byte counter with its largest value. A behavioural flash model drives decoy values on the unused input lanes, so a read that picks the wrong lane, or shifts its bits in the wrong order, shows up as corrupted bytes.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_DUMMY,
      ST_DATA,
      ST_TAIL,
      ST_GAP
   } sfq_state_e;

   localparam logic [1:0] LN_X1 = 2'd0;
   localparam logic [1:0] LN_X2 = 2'd1;
   localparam logic [1:0] LN_X4 = 2'd2;

   // bits moved per serial clock for a lane code
   function automatic logic [2:0] lane_bits(input logic [1:0] code);
      case (code)
         LN_X2:   lane_bits = 3'd2;
         LN_X4:   lane_bits = 3'd4;
         default: lane_bits = 3'd1;
      endcase
   endfunction

   // serial clocks per byte, minus one
   function automatic logic [2:0] cyc_m1(input logic [1:0] code);
      case (code)
         LN_X2:   cyc_m1 = 3'd3;
         LN_X4:   cyc_m1 = 3'd1;
         default: cyc_m1 = 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/sfq_sck_gen.sv
module sfq_sck_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic lead_o,
   output logic trail_o
);
   localparam int HALF  = CLK_DIV / 2;
   localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

   logic [CNT_W-1:0] cnt;
   logic             sclk_q;

   assign lead_o  = run_i && (cnt == CNT_W'(HALF - 1));
   assign trail_o = run_i && (cnt == CNT_W'(CLK_DIV - 1));
   assign sclk_o  = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else if (!run_i) begin
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else begin
         cnt <= trail_o ? '0 : cnt + 1'b1;
         if (lead_o)       sclk_q <= 1'b1;
         else if (trail_o) sclk_q <= 1'b0;
      end
   end

   // R8: the serial clock stays low when the generator is stopped
   a_r8_stopped_low : assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !sclk_q);

endmodule

// File: rtl/sfq_lane_map.sv
module sfq_lane_map
   import sfq_pkg::*;
(
   input  logic [7:0] sh_i,
   input  logic [1:0] lanes_i,
   input  logic       drive_i,
   input  logic [7:0] rx_sh_i,
   input  logic [3:0] io_in_i,
   output logic [3:0] io_out_o,
   output logic [3:0] io_oe_o,
   output logic [7:0] rx_next_o
);
   for (genvar g = 0; g < 4; g++) begin : g_lane
      logic x4b, x2b, x1b;
      logic x2e, x1e;
      assign x4b = sh_i[4+g];
      if (g < 2) begin : g_dual
         assign x2b = sh_i[6+g];
         assign x2e = 1'b1;
      end else begin : g_nodual
         assign x2b = 1'b0;
         assign x2e = 1'b0;
      end
      if (g == 0) begin : g_single
         assign x1b = sh_i[7];
         assign x1e = 1'b1;
      end else begin : g_nosingle
         assign x1b = 1'b0;
         assign x1e = 1'b0;
      end
      assign io_out_o[g] = drive_i & ((lanes_i == LN_X4) ? x4b :
                                      (lanes_i == LN_X2) ? x2b : x1b);
      assign io_oe_o[g]  = drive_i & ((lanes_i == LN_X4) ? 1'b1 :
                                      (lanes_i == LN_X2) ? x2e : x1e);
   end

   always_comb begin
      case (lanes_i)
         LN_X4:   rx_next_o = {rx_sh_i[3:0], io_in_i[3:0]};
         LN_X2:   rx_next_o = {rx_sh_i[5:0], io_in_i[1:0]};
         default: rx_next_o = {rx_sh_i[6:0], io_in_i[1]};
      endcase
   end

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
   import sfq_pkg::*;
#(
   parameter int CLK_DIV        = 4,
   parameter int ADDR_BYTES     = 3,
   parameter int MAX_DUMMY      = 31,
   parameter int MAX_DATA_BYTES = 4096,
   localparam int ADDR_W = 8 * ADDR_BYTES,
   localparam int ALEN_W = $clog2(ADDR_BYTES + 1),
   localparam int DUM_W  = $clog2(MAX_DUMMY + 1),
   localparam int LEN_W  = $clog2(MAX_DATA_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [7:0]        cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ALEN_W-1:0] alen_i,
   input  logic [1:0]        addr_lanes_i,
   input  logic [DUM_W-1:0]  dummy_i,
   input  logic [LEN_W-1:0]  dlen_i,
   input  logic [1:0]        data_lanes_i,
   input  logic              write_i,
   input  logic [7:0]        tx_data_i,
   output logic              tx_pop_o,
   output logic [7:0]        rx_data_o,
   output logic              rx_valid_o,
   output logic              busy_o,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic [3:0]        io_out_o,
   output logic [3:0]        io_oe_o,
   input  logic [3:0]        io_in_i
);
   localparam int HALF   = CLK_DIV / 2;
   localparam int WAIT_W = $clog2(2 * CLK_DIV);
   localparam int HI_W   = $clog2(2 * CLK_DIV + 1) + 1;

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("sflash_seq: CLK_DIV must be even and at least 2");
   end
   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("sflash_seq: ADDR_BYTES must lie in 1..4");
   end
   if (MAX_DATA_BYTES < 1 || MAX_DUMMY < 1) begin : g_bad_len
      $error("sflash_seq: data and dummy limits must be positive");
   end

   sfq_state_e        state, nxt_ph;
   logic [7:0]        sh, rx_sh, rx_data;
   logic [ADDR_W-1:0] a_sh, a_align;
   logic [2:0]        bit_left;
   logic [LEN_W-1:0]  byte_left, dlen_q;
   logic [DUM_W-1:0]  dum_left, dum_q;
   logic [ALEN_W-1:0] alen_q;
   logic [1:0]        alanes_q, dlanes_q, cur_lanes;
   logic              wr_q, cs_n, rx_valid;
   logic [WAIT_W-1:0] wait_cnt;
   logic              run, lead, trail, ph_end, drive, rd_cap;
   logic [7:0]        rx_next;

   // ---------------- serial clock ----------------
   assign run = (state == ST_CMD) || (state == ST_ADDR) ||
                (state == ST_DUMMY) || (state == ST_DATA);

   sfq_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .sclk_o  (sclk_o),
      .lead_o  (lead),
      .trail_o (trail)
   );

   // ---------------- lane mapping ----------------
   always_comb begin
      case (state)
         ST_ADDR: begin cur_lanes = alanes_q; drive = 1'b1; end
         ST_DATA: begin cur_lanes = dlanes_q; drive = wr_q; end
         ST_CMD:  begin cur_lanes = LN_X1;    drive = 1'b1; end
         default: begin cur_lanes = LN_X1;    drive = 1'b0; end
      endcase
   end

   sfq_lane_map u_lanes (
      .sh_i      (sh),
      .lanes_i   (cur_lanes),
      .drive_i   (drive),
      .rx_sh_i   (rx_sh),
      .io_in_i   (io_in_i),
      .io_out_o  (io_out_o),
      .io_oe_o   (io_oe_o),
      .rx_next_o (rx_next)
   );

   // ---------------- phase sequencing ----------------
   always_comb begin
      if (int'(alen_i) >= ADDR_BYTES) a_align = addr_i;
      else a_align = addr_i << (8 * (ADDR_BYTES - int'(alen_i)));
   end

   always_comb begin
      case (state)
         ST_CMD:   ph_end = (bit_left == 3'd0);
         ST_DUMMY: ph_end = (dum_left == '0);
         default:  ph_end = (bit_left == 3'd0) && (byte_left == '0);
      endcase
   end

   always_comb begin
      sfq_state_e after_dum, after_addr, after_cmd;
      after_dum  = (dlen_q != '0) ? ST_DATA : ST_TAIL;
      after_addr = (dum_q != '0)  ? ST_DUMMY : after_dum;
      after_cmd  = (alen_q != '0) ? ST_ADDR : after_addr;
      case (state)
         ST_CMD:   nxt_ph = after_cmd;
         ST_ADDR:  nxt_ph = after_addr;
         ST_DUMMY: nxt_ph = after_dum;
         default:  nxt_ph = ST_TAIL;
      endcase
   end

   assign rd_cap   = (state == ST_DATA) && !wr_q;
   assign tx_pop_o = trail && wr_q &&
                     ((ph_end && nxt_ph == ST_DATA) ||
                      (!ph_end && state == ST_DATA && bit_left == 3'd0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cs_n      <= 1'b1;
         sh        <= '0;
         a_sh      <= '0;
         bit_left  <= '0;
         byte_left <= '0;
         dum_left  <= '0;
         wait_cnt  <= '0;
         alen_q    <= '0;
         alanes_q  <= LN_X1;
         dlanes_q  <= LN_X1;
         dum_q     <= '0;
         dlen_q    <= '0;
         wr_q      <= 1'b0;
         rx_sh     <= '0;
         rx_data   <= '0;
         rx_valid  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  alen_q   <= alen_i;
                  alanes_q <= addr_lanes_i;
                  dlanes_q <= data_lanes_i;
                  dum_q    <= dummy_i;
                  dlen_q   <= dlen_i;
                  wr_q     <= write_i;
                  a_sh     <= a_align;
                  sh       <= cmd_i;
                  bit_left <= 3'd7;
                  cs_n     <= 1'b0;
                  state    <= ST_CMD;
               end
            end
            ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA: begin
               if (lead && rd_cap) begin
                  rx_sh <= rx_next;
                  if (bit_left == 3'd0) begin
                     rx_data  <= rx_next;
                     rx_valid <= 1'b1;
                  end
               end
               if (trail) begin
                  if (ph_end) begin
                     state <= nxt_ph;
                     case (nxt_ph)
                        ST_ADDR: begin
                           sh        <= a_sh[ADDR_W-1 -: 8];
                           a_sh      <= a_sh << 8;
                           byte_left <= LEN_W'(alen_q) - 1'b1;
                           bit_left  <= cyc_m1(alanes_q);
                        end
                        ST_DUMMY: dum_left <= dum_q - 1'b1;
                        ST_DATA: begin
                           byte_left <= dlen_q - 1'b1;
                           bit_left  <= cyc_m1(dlanes_q);
                           if (wr_q) sh <= tx_data_i;
                        end
                        default: wait_cnt <= WAIT_W'(HALF - 1);
                     endcase
                  end else if (state == ST_DUMMY) begin
                     dum_left <= dum_left - 1'b1;
                  end else if (bit_left == 3'd0) begin
                     byte_left <= byte_left - 1'b1;
                     bit_left  <= cyc_m1(cur_lanes);
                     if (state == ST_ADDR) begin
                        sh   <= a_sh[ADDR_W-1 -: 8];
                        a_sh <= a_sh << 8;
                     end else if (wr_q) begin
                        sh <= tx_data_i;
                     end
                  end else begin
                     sh       <= sh << lane_bits(cur_lanes);
                     bit_left <= bit_left - 1'b1;
                  end
               end
            end
            ST_TAIL: begin
               if (wait_cnt == '0) begin
                  cs_n     <= 1'b1;
                  wait_cnt <= WAIT_W'(2 * CLK_DIV - 1);
                  state    <= ST_GAP;
               end else begin
                  wait_cnt <= wait_cnt - 1'b1;
               end
            end
            default: begin
               if (wait_cnt == '0) state <= ST_IDLE;
               else wait_cnt <= wait_cnt - 1'b1;
            end
         endcase
      end
   end

   assign busy_o     = (state != ST_IDLE);
   assign cs_n_o     = cs_n;
   assign rx_data_o  = rx_data;
   assign rx_valid_o = rx_valid;

   // ---------------- checks ----------------
   logic [HI_W-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     hi_cnt <= '1;
      else if (!cs_n)                 hi_cnt <= '0;
      else if (hi_cnt != '1)          hi_cnt <= hi_cnt + 1'b1;
   end

   // R2: chip select low only inside a busy window
   a_r2_select_busy : assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_o |-> busy_o);
   // R9: busy drops only once chip select is high
   a_r9_busy_covers_gap : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> cs_n_o);
   // R9: minimum deselect time before reselect
   a_r9_deselect_gap : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (hi_cnt >= HI_W'(2 * CLK_DIV)));
   // R3: opcode uses lane 0 only
   a_r3_cmd_one_lane : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD) |-> (io_oe_o == 4'b0001));
   // R5: lanes released during dummy cycles
   a_r5_dummy_released : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DUMMY) |-> (io_oe_o == 4'b0000));
   // R6: byte takes only in write transactions
   a_r6_pop_only_write : assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop_o |-> (wr_q && !cs_n_o));
   // R7: received bytes only in read transactions, lanes released
   a_r7_rx_only_read : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> (!wr_q && busy_o && io_oe_o == 4'b0000));
   // R8: serial clock idle while deselected
   a_r8_sclk_idle : assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o);

endmodule

// File: tb/sflash_seq_bench.sv
`timescale 1ns/1ps
module sflash_seq_bench;
   localparam int BDIV = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  cmd_i = '0;
   logic [23:0] addr_i = '0;
   logic [1:0]  alen_i = '0;
   logic [1:0]  addr_lanes_i = '0;
   logic [4:0]  dummy_i = '0;
   logic [12:0] dlen_i = '0;
   logic [1:0]  data_lanes_i = '0;
   logic        write_i = 1'b0;
   logic [7:0]  tx_data_i = '0;
   logic        tx_pop_o, rx_valid_o, busy_o, cs_n_o, sclk_o;
   logic [7:0]  rx_data_o;
   logic [3:0]  io_out_o, io_oe_o;
   logic [3:0]  io_in_i = '0;

   always #2.5 clk = ~clk;

   sflash_seq #(.CLK_DIV(BDIV)) u_sflash_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
      .addr_i(addr_i), .alen_i(alen_i), .addr_lanes_i(addr_lanes_i),
      .dummy_i(dummy_i), .dlen_i(dlen_i), .data_lanes_i(data_lanes_i),
      .write_i(write_i), .tx_data_i(tx_data_i), .tx_pop_o(tx_pop_o),
      .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .busy_o(busy_o),
      .cs_n_o(cs_n_o), .sclk_o(sclk_o), .io_out_o(io_out_o),
      .io_oe_o(io_oe_o), .io_in_i(io_in_i)
   );

   int nchk = 0, nfail = 0;
   bit done = 0;

   // expected-transaction description (bench side)
   int g_cmd, g_addr, g_alen, g_al, g_dum, g_dlen, g_dl, g_dstart;
   bit g_wr;

   // capture state
   logic [3:0] cap_out [0:8399];
   logic [3:0] cap_oe  [0:8399];
   int         rise_cyc[0:8399];
   logic [7:0] rx_arr  [0:4095];
   int ncap = 0, nrx = 0, npop = 0, tx_idx = 0, cyc = 0;
   int cs_hi = 0, last_hi = 0;
   bit pop_seen = 0;

   function automatic int cpb(int code);
      return (code == 1) ? 4 : (code == 2) ? 2 : 8;
   endfunction
   function automatic logic [3:0] lmask(int code);
      return (code == 1) ? 4'b0011 : (code == 2) ? 4'b1111 : 4'b0001;
   endfunction
   function automatic logic [3:0] slice(logic [7:0] b, int code, int c);
      if (code == 1) return {2'b00, b[7-2*c -: 2]};
      if (code == 2) return b[7-4*c -: 4];
      return {3'b000, b[7-c]};
   endfunction
   function automatic logic [7:0] rdpat(int k);
      return 8'((k * 29) ^ 165 ^ (k >> 3));
   endfunction
   function automatic logic [7:0] txbyte(int k);
      return 8'((k * 7) ^ 195);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // flash model: capture lanes at each rising serial edge
   always @(posedge sclk_o) begin
      if (ncap < 8400) begin
         cap_out[ncap]  = io_out_o;
         cap_oe[ncap]   = io_oe_o;
         rise_cyc[ncap] = cyc;
      end
      ncap++;
   end

   // flash model: present read data after each falling serial edge
   always @(negedge sclk_o) begin
      int j, c;
      logic [7:0] b;
      j = ncap - g_dstart;
      if (!g_wr && j >= 0 && j < g_dlen * cpb(g_dl)) begin
         b = rdpat(j / cpb(g_dl));
         c = j % cpb(g_dl);
         if (g_dl == 1)      io_in_i = {2'b01, b[7-2*c -: 2]};
         else if (g_dl == 2) io_in_i = b[7-4*c -: 4];
         else                io_in_i = {1'b1, 1'b0, b[7-c], ~b[7-c]};
      end else begin
         io_in_i = 4'b0110;
      end
   end

   // byte streams and deselect timing, sampled away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (pop_seen) tx_idx++;
      pop_seen = tx_pop_o;
      if (tx_pop_o) npop++;
      tx_data_i = txbyte(tx_idx);
      if (rx_valid_o) begin
         if (nrx < 4096) rx_arr[nrx] = rx_data_o;
         nrx++;
      end
      if (cs_n_o) cs_hi++;
      else begin
         if (cs_hi != 0) last_hi = cs_hi;
         cs_hi = 0;
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (busy_o) @(negedge clk);
   endtask

   task automatic launch(int cmd, int addr, int alen, int al, int dum,
                         int dlen, int dl, bit wr);
      g_cmd = cmd; g_addr = addr; g_alen = alen; g_al = al;
      g_dum = dum; g_dlen = dlen; g_dl = dl; g_wr = wr;
      g_dstart = 8 + alen * cpb(al) + dum;
      @(negedge clk);
      ncap = 0; nrx = 0; npop = 0; tx_idx = 0; pop_seen = 0;
      tx_data_i = txbyte(0);
      cmd_i = 8'(cmd); addr_i = 24'(addr); alen_i = 2'(alen);
      addr_lanes_i = 2'(al); dummy_i = 5'(dum); dlen_i = 13'(dlen);
      data_lanes_i = 2'(dl); write_i = wr; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic verify(string tag);
      int n, bad3, bad4, bad5, bad6, bad7, exp_n, fi, fa, fe;
      logic [3:0] eo, em;
      logic [7:0] b;
      bad3 = 0; bad4 = 0; bad5 = 0; bad6 = 0; bad7 = 0; fi = -1; fa = 0; fe = 0;
      exp_n = g_dstart + g_dlen * cpb(g_dl);
      chk(ncap == exp_n, {"R8 serial edge count ", tag}, ncap, exp_n);
      n = 0;
      for (int i = 0; i < 8; i++) begin
         eo = {3'b000, g_cmd[7-i]};
         if (cap_oe[n] != 4'b0001 || (cap_out[n] & 4'b0001) != eo) begin
            bad3++; if (fi < 0) begin fi = n; fa = cap_out[n]; fe = eo; end
         end
         n++;
      end
      for (int a = 0; a < g_alen; a++) begin
         b = 8'(g_addr >> (8 * (g_alen - 1 - a)));
         for (int c = 0; c < cpb(g_al); c++) begin
            eo = slice(b, g_al, c); em = lmask(g_al);
            if (cap_oe[n] != em || (cap_out[n] & em) != eo) bad4++;
            n++;
         end
      end
      for (int d = 0; d < g_dum; d++) begin
         if (cap_oe[n] != 4'b0000) bad5++;
         n++;
      end
      for (int k = 0; k < g_dlen; k++) begin
         for (int c = 0; c < cpb(g_dl); c++) begin
            if (n < 8400) begin
               if (g_wr) begin
                  eo = slice(txbyte(k), g_dl, c); em = lmask(g_dl);
                  if (cap_oe[n] != em || (cap_out[n] & em) != eo) bad6++;
               end else if (cap_oe[n] != 4'b0000) bad7++;
            end
            n++;
         end
      end
      chk(bad3 == 0, {"R3 opcode lane/bits ", tag}, fa, fe);
      if (g_alen > 0) chk(bad4 == 0, {"R4 address bits ", tag}, bad4, 0);
      if (g_dum > 0)  chk(bad5 == 0, {"R5 dummy released ", tag}, bad5, 0);
      if (g_wr) begin
         chk(npop == g_dlen, {"R6 byte takes ", tag}, npop, g_dlen);
         if (g_dlen > 0) chk(bad6 == 0, {"R6 write data lanes ", tag}, bad6, 0);
      end else begin
         chk(nrx == g_dlen, {"R7 received count ", tag}, nrx, g_dlen);
         if (g_dlen > 0) begin
            int rbad, ra, re;
            rbad = 0; ra = 0; re = 0;
            chk(bad7 == 0, {"R7 lanes released ", tag}, bad7, 0);
            for (int k = 0; k < g_dlen && k < 4096; k++)
               if (rx_arr[k] !== rdpat(k)) begin
                  if (rbad == 0) begin ra = rx_arr[k]; re = rdpat(k); end
                  rbad++;
               end
            chk(rbad == 0, {"R7 received data ", tag}, ra, re);
         end
      end
   endtask

   task automatic run_txn(int cmd, int addr, int alen, int al, int dum,
                          int dlen, int dl, bit wr, string tag);
      launch(cmd, addr, alen, al, dum, dlen, dl, wr);
      wait_idle();
      verify(tag);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(cs_n_o == 1'b1, "R1 cs_n after reset", cs_n_o, 1);
      chk(sclk_o == 1'b0, "R1 sclk after reset", sclk_o, 0);
      chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
      chk(io_oe_o == 4'b0000, "R1 oe after reset", io_oe_o, 0);
      chk(rx_valid_o == 1'b0 && tx_pop_o == 1'b0, "R1 strobes after reset",
          {rx_valid_o, tx_pop_o}, 0);
   endtask

   task automatic t_reg_get();  run_txn(8'h0F, 8'hB0, 1, 0, 0, 1, 0, 0, "reg get"); endtask
   task automatic t_reg_set();  run_txn(8'h1F, 8'hA0, 1, 0, 0, 1, 0, 1, "reg set"); endtask
   task automatic t_die_sel();  run_txn(8'hC2, 8'h01, 1, 0, 0, 1, 0, 1, "die select"); endtask
   task automatic t_cache_x1(); run_txn(8'h0B, 16'h0123, 2, 0, 8, 4, 0, 0, "x1 cache read"); endtask
   task automatic t_quad_out(); run_txn(8'h6B, 16'h0A5C, 2, 0, 8, 5, 2, 0, "x4 output read"); endtask
   task automatic t_dual_io();  run_txn(8'hBB, 16'h3C96, 2, 1, 4, 6, 1, 0, "x2 io read"); endtask
   task automatic t_quad_io();  run_txn(8'hEB, 16'h7E81, 2, 2, 4, 3, 2, 0, "x4 io read"); endtask
   task automatic t_quad_load(); run_txn(8'h32, 16'h0040, 2, 0, 0, 6, 2, 1, "x4 program load"); endtask
   task automatic t_dual_write(); run_txn(8'hA2, 24'h5A5A5A, 3, 1, 0, 3, 1, 1, "x2 write"); endtask
   task automatic t_nor_read(); run_txn(8'h03, 24'hABCDEF, 3, 0, 0, 2, 0, 0, "3-byte read"); endtask

   task automatic t_cmd_only();
      // R10: opcode only, all other phases empty
      run_txn(8'h06, 0, 0, 0, 0, 0, 0, 1, "R10 opcode only");
      chk(ncap == 8, "R10 opcode-only edges", ncap, 8);
   endtask

   task automatic t_no_data();
      // R10: address then dummy, zero data bytes
      run_txn(8'hD8, 16'h1234, 2, 0, 3, 0, 0, 0, "R10 no data");
   endtask

   task automatic t_full_len();
      run_txn(8'h6B, 16'h0000, 2, 0, 8, 4096, 2, 0, "4096-byte x4 read");
      chk(rise_cyc[1] - rise_cyc[0] == BDIV, "R8 serial clock period",
          rise_cyc[1] - rise_cyc[0], BDIV);
   endtask

   task automatic t_start_busy();
      launch(8'h3B, 16'h0F0F, 2, 0, 8, 4, 1, 0);
      chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
      repeat (40) @(negedge clk);
      cmd_i = 8'hFF; alen_i = 2'd0; dummy_i = 5'd0; dlen_i = 13'd1;
      data_lanes_i = 2'd2; write_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_idle();
      verify("R2 start while busy");
      begin
         int sel;
         sel = 0;
         repeat (60) begin
            @(negedge clk);
            if (!cs_n_o || busy_o) sel++;
         end
         chk(sel == 0, "R2 no queued transaction", sel, 0);
      end
   endtask

   task automatic t_back_to_back();
      run_txn(8'h06, 0, 0, 0, 0, 0, 0, 1, "gap first");
      launch(8'h0F, 8'hC0, 1, 0, 0, 1, 0, 0);
      chk(last_hi >= 2 * BDIV, "R9 deselect gap", last_hi, 2 * BDIV);
      wait_idle();
      verify("gap second");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reg_get();
      t_reg_set();
      t_die_sel();
      t_cache_x1();
      t_quad_out();
      t_dual_io();
      t_quad_io();
      t_quad_load();
      t_dual_write();
      t_nor_read();
      t_cmd_only();
      t_no_data();
      t_start_busy();
      t_back_to_back();
      t_full_len();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule